// File: doc/BRIEF.md
# Result Broadcast Bus Arbiter

Several functional units in an out-of-order core can finish work in the same cycle, but only one shared result bus carries completions to the waiting consumers. This block takes one request from each unit. A request is a valid bit, a producer tag that names the station producing the value, and a data word. Each cycle the block selects one winner in round-robin order. It returns a one-hot grant to that unit in the same cycle and places the winner's tag and data on the bus one clock later. Every consumer watches the bus and compares the tag with the producers it is waiting for. The bus never carries a destination register.

A unit that loses keeps its request asserted, with tag and data unchanged, and tries again on later cycles. A unit that sees its grant at a rising edge may release its station and withdraw or replace its request. Tag value zero means "no producer", so a request carrying tag zero is never granted and never broadcast.

The bus side is a two-state machine. `BUS_IDLE` means no result is on the bus. `BUS_DRIVE` means a valid result is on the bus. The transitions are:
- IDLE-to-DRIVE, taken when a grant is issued.
- DRIVE-to-DRIVE, taken when a grant is issued in the next cycle.
- DRIVE-to-IDLE, taken when no requester is eligible.
- IDLE-to-IDLE, taken when no requester is eligible.

Reset puts the machine in `BUS_IDLE` and sets the round-robin pointer so that requester 0 has first priority.

Top module: `rbus_arbiter`

## Requirements
- R1: At most one bit of `req_grant` is high in any cycle.
- R2: If `req_grant[i]` is high in cycle t, then in cycle t+1 `bus_valid` is 1, `bus_tag` equals requester i's tag at t, and `bus_data` equals requester i's data at t. The bus is 64 data bits plus a 4-bit producer tag.
- R3: If no grant is issued in cycle t, then in cycle t+1 `bus_valid` is 0 and `bus_tag` and `bus_data` are all zeros.
- R4: A request whose tag is 4'h0 is ignored: it receives no grant and is never broadcast, and `bus_tag` is never 0 while `bus_valid` is 1.
- R5: The search for a winner starts at the index one above the last winner and wraps around. After reset the last winner is taken to be NUM_REQ-1, so requester 0 has priority first.
- R6: While `rst_n` is low, `req_grant` and `bus_valid` are 0 whatever the requests are.
- R7: When all NUM_REQ requesters stay eligible, each one is granted exactly once in every NUM_REQ consecutive cycles. A loser that keeps its request is eventually granted.
- R8: A grant goes only to a requester whose `req_valid` bit is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_REQ | One request bit per functional unit |
| req_tag | input | NUM_REQ*TAG_W | Producer tags; requester i occupies bits [i*TAG_W +: TAG_W] |
| req_data | input | NUM_REQ*DATA_W | Result words; requester i occupies bits [i*DATA_W +: DATA_W] |
| req_grant | output | NUM_REQ | One-hot grant, same cycle as the request |
| bus_valid | output | 1 | Broadcast bus carries a result |
| bus_tag | output | TAG_W | Producer tag on the bus |
| bus_data | output | DATA_W | Result word on the bus |

## Verification
Two things overlap in almost every busy cycle. The bus shows the result granted in the previous cycle while a new grant for the current cycle is decided among the requests that are still pending, and several units often ask for the bus at once. The random phase keeps many requesters pending together, so that the registered broadcast and the combinational round-robin choice meet in the same clock. Each cycle is judged against a reference pointer kept in the bench: the grant vector is compared in the middle of the cycle, and the bus is compared one cycle later against the winner's held tag and data.

// File: rtl/rbus_pkg.sv
package rbus_pkg;
    typedef enum logic [0:0] {
        BUS_IDLE  = 1'b0,
        BUS_DRIVE = 1'b1
    } bus_state_e;
endpackage

// File: rtl/rbus_rr_pick.sv
// Round-robin selector: searches upward from the entry above `last`.
module rbus_rr_pick #(
    parameter int NUM_REQ = 4,
    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ-1:0] req,
    input  logic [IDX_W-1:0]   last,
    output logic [NUM_REQ-1:0] gnt,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int k = 1; k <= NUM_REQ; k++) begin
            int c;
            logic [IDX_W-1:0] ci;
            c  = (int'(last) + k) % NUM_REQ;
            ci = IDX_W'(c);
            if (!any && req[ci]) begin
                any     = 1'b1;
                gnt[ci] = 1'b1;
                idx     = ci;
            end
        end
    end
endmodule

// File: rtl/rbus_mux.sv
// Picks the winner's tag and data out of the flattened request vectors.
module rbus_mux #(
    parameter int NUM_REQ = 4,
    parameter int DATA_W  = 64,
    parameter int TAG_W   = 4,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ*TAG_W-1:0]  tags,
    input  logic [NUM_REQ*DATA_W-1:0] datas,
    input  logic [IDX_W-1:0]          sel,
    output logic [TAG_W-1:0]          tag,
    output logic [DATA_W-1:0]         data
);
    always_comb begin
        tag  = tags[int'(sel)*TAG_W +: TAG_W];
        data = datas[int'(sel)*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/rbus_arbiter.sv
module rbus_arbiter
    import rbus_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int DATA_W  = 64,
    parameter int TAG_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [NUM_REQ*TAG_W-1:0]  req_tag,
    input  logic [NUM_REQ*DATA_W-1:0] req_data,
    output logic [NUM_REQ-1:0]        req_grant,
    output logic                      bus_valid,
    output logic [TAG_W-1:0]          bus_tag,
    output logic [DATA_W-1:0]         bus_data
);
    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
    localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(NUM_REQ - 1);

    bus_state_e          state_q, state_d;
    logic [IDX_W-1:0]    last_q;
    logic [TAG_W-1:0]    tag_q;
    logic [DATA_W-1:0]   data_q;
    logic [NUM_REQ-1:0]  elig;
    logic [NUM_REQ-1:0]  pick_gnt;
    logic                pick_any;
    logic [IDX_W-1:0]    pick_idx;
    logic [TAG_W-1:0]    win_tag;
    logic [DATA_W-1:0]   win_data;

    // A tag of zero marks "no producer" and never competes (R4).
    generate
        for (genvar i = 0; i < NUM_REQ; i++) begin : g_elig
            assign elig[i] = req_valid[i] && (req_tag[i*TAG_W +: TAG_W] != '0);
        end
    endgenerate

    rbus_rr_pick #(.NUM_REQ(NUM_REQ)) u_pick (
        .req  (elig),
        .last (last_q),
        .gnt  (pick_gnt),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    rbus_mux #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_mux (
        .tags  (req_tag),
        .datas (req_data),
        .sel   (pick_idx),
        .tag   (win_tag),
        .data  (win_data)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  state_d = pick_any ? BUS_DRIVE : BUS_IDLE;
            BUS_DRIVE: state_d = pick_any ? BUS_DRIVE : BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    // State register plus winner capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            last_q  <= LAST_INIT;
            tag_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (pick_any) begin
                last_q <= pick_idx;
                tag_q  <= win_tag;
                data_q <= win_data;
            end else begin
                tag_q  <= '0;
                data_q <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        req_grant = rst_n ? pick_gnt : '0;
        bus_valid = (state_q == BUS_DRIVE);
        bus_tag   = tag_q;
        bus_data  = data_q;
    end

    // Assertions
    a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant));

    a_r3_idle_after_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant == '0) |=> (!bus_valid && bus_tag == '0 && bus_data == '0));

    a_r4_no_zero_tag_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_tag != '0));

    generate
        for (genvar i = 0; i < NUM_REQ; i++) begin : g_chk
            a_r2_bus_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
                req_grant[i] |=> (bus_valid
                    && bus_tag  == $past(req_tag[i*TAG_W +: TAG_W])
                    && bus_data == $past(req_data[i*DATA_W +: DATA_W])));

            a_r8_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
                req_grant[i] |-> req_valid[i]);
        end
    endgenerate
endmodule

// File: tb/rbus_arbiter_tb.sv
`timescale 1ns/1ps
module rbus_arbiter_tb;
    localparam int N  = 4;
    localparam int DW = 64;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N*TW-1:0] req_tag   = '0;
    logic [N*DW-1:0] req_data  = '0;
    logic [N-1:0]    req_grant;
    logic            bus_valid;
    logic [TW-1:0]   bus_tag;
    logic [DW-1:0]   bus_data;

    rbus_arbiter #(.NUM_REQ(N), .DATA_W(DW), .TAG_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
        .req_data(req_data), .req_grant(req_grant), .bus_valid(bus_valid),
        .bus_tag(bus_tag), .bus_data(bus_data)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [N-1:0]  pend;
    logic [TW-1:0] tag_b  [N];
    logic [DW-1:0] data_b [N];
    int            ptr;
    logic          exp_v;
    logic [TW-1:0] exp_t;
    logic [DW-1:0] exp_d;
    logic [N-1:0]  last_grant;

    task automatic check(input bit ok, input string rq, input logic [DW+TW:0] act,
                         input logic [DW+TW:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, expv);
        end
    endtask

    function automatic int pick_exp(input logic [N-1:0] e, input int p);
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (p + k) % N;
            if (e[c]) return c;
        end
        return -1;
    endfunction

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            req_valid[i]           = pend[i];
            req_tag[i*TW +: TW]    = tag_b[i];
            req_data[i*DW +: DW]   = data_b[i];
        end
    endtask

    // One cycle: check the bus from the previous grant, then present and judge the new grant.
    task automatic step(input bit rnd);
        logic [N-1:0] e;
        logic [N-1:0] eg;
        int w;
        @(negedge clk);
        check(bus_valid == exp_v && bus_tag == exp_t && bus_data == exp_d,
              exp_v ? "R2 bus carries winner" : "R3 bus idle",
              {bus_valid, bus_tag, bus_data}, {exp_v, exp_t, exp_d});
        if (rnd) begin
            for (int i = 0; i < N; i++) begin
                if (!pend[i] && ($urandom % 3 == 0)) begin
                    pend[i]   = 1'b1;
                    tag_b[i]  = TW'(1 + ($urandom % 15));
                    data_b[i] = {$urandom, $urandom};
                end
            end
        end
        drive();
        #1;
        for (int i = 0; i < N; i++) e[i] = pend[i] && (tag_b[i] != '0);
        w  = pick_exp(e, ptr);
        eg = (w >= 0) ? (N'(1) << w) : '0;
        last_grant = req_grant;
        check(req_grant == eg, "R1/R5/R8 grant vector", {{(DW+TW+1-N){1'b0}}, req_grant},
              {{(DW+TW+1-N){1'b0}}, eg});
        if (w >= 0) begin
            exp_v = 1'b1; exp_t = tag_b[w]; exp_d = data_b[w];
            pend[w] = 1'b0;
            ptr = w;
        end else begin
            exp_v = 1'b0; exp_t = '0; exp_d = '0;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        pend = '0; ptr = N - 1;
        exp_v = 1'b0; exp_t = '0; exp_d = '0;
        for (int i = 0; i < N; i++) begin tag_b[i] = TW'(i + 1); data_b[i] = '0; end

        // R6: requests during reset are not granted
        pend = '1;
        for (int i = 0; i < N; i++) data_b[i] = {32'hDEAD0000 + i, 32'h1};
        drive();
        #10;
        check(req_grant == '0 && bus_valid == 1'b0, "R6 reset state",
              {bus_valid, req_grant}, '0);
        @(negedge clk); @(negedge clk);
        pend = '0; drive();
        rst_n = 1'b1;

        // R5/R7: all four requesting continuously rotate 0,1,2,3,0,...
        for (int r = 0; r < 2 * N; r++) begin
            for (int i = 0; i < N; i++) begin
                pend[i] = 1'b1; tag_b[i] = TW'(i + 1);
                data_b[i] = {32'hA5A50000 + r, 32'h0 + i};
            end
            step(1'b0);
            check(last_grant == (N'(1) << (r % N)), "R7 fair rotation",
                  {{(DW+TW+1-N){1'b0}}, last_grant}, {{(DW+TW+1-N){1'b0}}, N'(1) << (r % N)});
        end
        pend = '0;
        step(1'b0);

        // R4: tag zero ignored even when alone
        pend = '0; pend[2] = 1'b1; tag_b[2] = '0; data_b[2] = 64'hFFFF_0000_FFFF_0000;
        step(1'b0);
        check(last_grant == '0, "R4 zero tag not granted",
              {{(DW+TW+1-N){1'b0}}, last_grant}, '0);
        step(1'b0);   // bus must be idle here (R3/R4)
        check(bus_valid == 1'b0, "R4 zero tag not broadcast", {{DW+TW{1'b0}}, bus_valid}, '0);
        pend = '0;
        step(1'b0);

        // R4 mixed: zero-tag requester beside a real one
        pend[1] = 1'b1; tag_b[1] = '0;
        pend[3] = 1'b1; tag_b[3] = 4'hF; data_b[3] = 64'h0123_4567_89AB_CDEF;
        step(1'b0);
        pend = '0;
        step(1'b0);   // bus carries requester 3 (R2)

        // Random: losers hold until granted (R1, R2, R3, R5, R7, R8)
        for (int i = 0; i < N; i++) tag_b[i] = TW'(i + 1);
        for (int c = 0; c < 400; c++) step(1'b1);

        // Drain pending requests, then idle
        for (int c = 0; c < 2 * N + 2; c++) step(1'b0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule